// File: doc/BRIEF.md
# SEC-DED Hamming Codec for 4-bit Words

This block protects 4-bit data words with an 8-bit code word of Hamming distance four. The encoder is purely combinational: it places the four data bits in the upper half of the code word and computes four check bits in the lower half. Each check bit is chosen so that a clean word always gives a zero syndrome.

The decoder takes a received 8-bit word and forms a 4-bit syndrome from it. Every column of the check matrix is non-zero, distinct and of odd weight, so the syndrome sorts each word into one of three cases. If the syndrome is zero, the word is clean. If the syndrome has odd weight, exactly one bit has flipped, and the syndrome points to that bit, which the decoder inverts. If the syndrome is non-zero and of even weight, two bits have flipped. The decoder reports this case and does not correct it.

The decoder has a valid/ready stream interface on both sides, with one output register. A word is accepted on a clock edge where `dec_in_valid` and `dec_in_ready` are both high. Its result appears on the output one cycle later. The output holds until a clock edge where `dec_out_valid` and `dec_out_ready` are both high. `dec_in_ready` is high whenever the output register is empty or is being drained in that same cycle. A stalled consumer therefore stops the producer without losing any word.

Top module: `secded_codec`

## Requirements
- R1: For data d (bit j of d sits at code bit 4+j), the encoder output has code[7:4] = d, code[0] = d0^d1^d2, code[1] = d0^d1^d3, code[2] = d0^d2^d3 and code[3] = d1^d2^d3.
- R2: A word that the encoder produced decodes to its own data, with both the corrected flag and the uncorrectable flag low.
- R3: A word with exactly one flipped bit, at any of the eight positions, decodes to the original data with the corrected flag high and the uncorrectable flag low.
- R4: A word with exactly two flipped bits raises the uncorrectable flag and keeps the corrected flag low. Its data output is bits [7:4] of the word as received, with no correction applied.
- R5: The corrected flag and the uncorrectable flag are never high together on a valid output.
- R6: A word accepted on a clock edge gives a valid output after that same edge, one cycle of latency.
- R7: While `dec_out_valid` is high and `dec_out_ready` is low, `dec_in_ready` is low, and the output data and flags stay unchanged.
- R8: After reset, `dec_out_valid` is low and `dec_in_ready` is high.
- R9: When an output is drained and no new word is accepted on the same edge, `dec_out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 4 | Data word to encode |
| enc_code | output | 8 | Code word: check bits in [3:0], data in [7:4] |
| dec_in_valid | input | 1 | Received word is offered |
| dec_in_ready | output | 1 | Decoder can take a word this cycle |
| dec_in_code | input | 8 | Received code word |
| dec_out_valid | output | 1 | Decoded result is present |
| dec_out_ready | input | 1 | Consumer takes the result this cycle |
| dec_out_data | output | 4 | Corrected (or raw, if uncorrectable) data |
| dec_out_corrected | output | 1 | A single-bit error was repaired |
| dec_out_uncorr | output | 1 | An error was detected that cannot be repaired |

## Verification
The code is fixed at four data bits and four check bits, so the bench builds the block at its only size. It sweeps all 16 data values through the encoder. For each value it then sends the clean word, all 8 single-bit flips and all 28 double-bit flips through the decoder. This covers every correctable and every detectable pattern of the code. A separate stall sequence holds back `dec_out_ready` while a second word waits at the input, which exercises the back-pressure and hold rules.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 4;
  localparam int CODE_W = DATA_W + CHK_W;

  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    data_t data;
    logic  corrected;
    logic  uncorr;
  } dec_res_t;

  // Check-matrix column for code position pos.
  // Check positions have identity columns; data positions have weight-3 columns.
  function automatic syn_t col_of(input int pos);
    syn_t one;
    one = syn_t'(1);
    if (pos < CHK_W) return one << pos;
    return ~(one << (CODE_W - 1 - pos));
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  syn_t chk;

  always_comb begin
    chk = '0;
    for (int i = 0; i < CHK_W; i++) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (col_of(CHK_W + j)[i]) chk[i] = chk[i] ^ data_i[j];
      end
    end
  end

  assign code_o = {data_i, chk};
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  code_t code_i,
  output syn_t  syn_o
);
  always_comb begin
    syn_o = '0;
    for (int i = 0; i < CHK_W; i++) begin
      for (int p = 0; p < CODE_W; p++) begin
        if (col_of(p)[i]) syn_o[i] = syn_o[i] ^ code_i[p];
      end
    end
  end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
(
  input  code_t    code_i,
  input  syn_t     syn_i,
  output dec_res_t res_o
);
  code_t hit;
  code_t fixed;
  logic  odd_w;

  always_comb begin
    for (int p = 0; p < CODE_W; p++) begin
      hit[p] = (syn_i == col_of(p));
    end
  end

  assign odd_w = ^syn_i;

  always_comb begin
    fixed           = code_i;
    res_o.corrected = 1'b0;
    res_o.uncorr    = 1'b0;
    if (syn_i == '0) begin
      fixed = code_i;
    end else if (odd_w && (|hit)) begin
      fixed           = code_i ^ hit;
      res_o.corrected = 1'b1;
    end else begin
      res_o.uncorr = 1'b1;
    end
    res_o.data = fixed[CODE_W-1:CHK_W];
  end
endmodule

// File: rtl/secded_pipe_reg.sv
module secded_pipe_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  logic         vld_q;
  logic [W-1:0] pay_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (in_valid && in_ready) pay_q <= in_payload;
    end
  end

  assign out_valid   = vld_q;
  assign out_payload = pay_q;
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data,
  output logic [CODE_W-1:0] enc_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic              dec_out_corrected,
  output logic              dec_out_uncorr
);
  localparam int RES_W = $bits(dec_res_t);

  syn_t     syn;
  dec_res_t res_d;
  dec_res_t res_q;

  secded_encoder u_enc (
    .data_i (enc_data),
    .code_o (enc_code)
  );

  secded_syndrome u_syn (
    .code_i (dec_in_code),
    .syn_o  (syn)
  );

  secded_corrector u_fix (
    .code_i (dec_in_code),
    .syn_i  (syn),
    .res_o  (res_d)
  );

  secded_pipe_reg #(.W(RES_W)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (dec_in_valid),
    .in_ready    (dec_in_ready),
    .in_payload  (res_d),
    .out_valid   (dec_out_valid),
    .out_ready   (dec_out_ready),
    .out_payload (res_q)
  );

  assign dec_out_data      = res_q.data;
  assign dec_out_corrected = res_q.corrected;
  assign dec_out_uncorr    = res_q.uncorr;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_in_valid,
  input logic       dec_in_ready,
  input logic       dec_out_valid,
  input logic       dec_out_ready,
  input logic [3:0] dec_out_data,
  input logic       dec_out_corrected,
  input logic       dec_out_uncorr
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !(dec_out_corrected && dec_out_uncorr));

  // R6
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && dec_in_ready) |=> dec_out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && !dec_out_ready) |=> (dec_out_valid && $stable(dec_out_data)
      && $stable(dec_out_corrected) && $stable(dec_out_uncorr)));

  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_ready |-> (dec_out_valid && !dec_out_ready));

  // R9
  drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_ready && !dec_in_valid) |=> !dec_out_valid);
endmodule

bind secded_codec secded_codec_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .dec_in_valid      (dec_in_valid),
  .dec_in_ready      (dec_in_ready),
  .dec_out_valid     (dec_out_valid),
  .dec_out_ready     (dec_out_ready),
  .dec_out_data      (dec_out_data),
  .dec_out_corrected (dec_out_corrected),
  .dec_out_uncorr    (dec_out_uncorr)
);

// File: tb/secded_codec_bench.sv
`timescale 1ns/1ps
module secded_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] enc_data = '0;
  logic [7:0] enc_code;
  logic       dec_in_valid = 1'b0;
  logic       dec_in_ready;
  logic [7:0] dec_in_code = '0;
  logic       dec_out_valid;
  logic       dec_out_ready = 1'b1;
  logic [3:0] dec_out_data;
  logic       dec_out_corrected;
  logic       dec_out_uncorr;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  secded_codec u_secded_codec (
    .clk               (clk),
    .rst_n             (rst_n),
    .enc_data          (enc_data),
    .enc_code          (enc_code),
    .dec_in_valid      (dec_in_valid),
    .dec_in_ready      (dec_in_ready),
    .dec_in_code       (dec_in_code),
    .dec_out_valid     (dec_out_valid),
    .dec_out_ready     (dec_out_ready),
    .dec_out_data      (dec_out_data),
    .dec_out_corrected (dec_out_corrected),
    .dec_out_uncorr    (dec_out_uncorr)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_code(input logic [3:0] d);
    return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3], d[0]^d[1]^d[2]};
  endfunction

  // Offer one word, then check the registered result one cycle later.
  task automatic xfer(input logic [7:0] w, input logic [3:0] ed, input bit ec, input bit eu, input string req);
    logic [5:0] act;
    logic [5:0] exp;
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_code  = w;
    @(negedge clk);
    dec_in_valid = 1'b0;
    act = {dec_out_data, dec_out_corrected, dec_out_uncorr};
    exp = {ed, ec, eu};
    chk(dec_out_valid === 1'b1, "R6", {7'd0, dec_out_valid}, 8'd1);
    chk(act === exp, req, {2'b0, act}, {2'b0, exp});
    chk(!(dec_out_corrected && dec_out_uncorr), "R5", {6'd0, dec_out_corrected, dec_out_uncorr}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    chk(dec_out_valid === 1'b0, "R8", {7'd0, dec_out_valid}, 8'd0);
    chk(dec_in_ready === 1'b1, "R8", {7'd0, dec_in_ready}, 8'd1);

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      enc_data = 4'(d);
      #1;
      cw = ref_code(4'(d));
      // R1
      chk(enc_code === cw, "R1", enc_code, cw);
      // R2
      xfer(cw, 4'(d), 1'b0, 1'b0, "R2");
      // R3
      for (int i = 0; i < 8; i++) begin
        xfer(cw ^ (8'd1 << i), 4'(d), 1'b1, 1'b0, "R3");
      end
      // R4
      for (int i = 0; i < 8; i++) begin
        for (int j = i + 1; j < 8; j++) begin
          logic [7:0] rw;
          rw = cw ^ (8'd1 << i) ^ (8'd1 << j);
          xfer(rw, rw[7:4], 1'b0, 1'b1, "R4");
        end
      end
    end

    // R9: drained with no new word
    @(negedge clk);
    chk(dec_out_valid === 1'b0, "R9", {7'd0, dec_out_valid}, 8'd0);

    // R7: stall with a second word waiting
    @(negedge clk);
    dec_out_ready = 1'b0;
    dec_in_valid  = 1'b1;
    dec_in_code   = ref_code(4'h9);
    @(negedge clk);
    dec_in_code = ref_code(4'h6) ^ 8'h01;
    for (int k = 0; k < 3; k++) begin
      chk(dec_in_ready === 1'b0, "R7", {7'd0, dec_in_ready}, 8'd0);
      chk(dec_out_valid === 1'b1 && dec_out_data === 4'h9 && !dec_out_corrected,
          "R7", {dec_out_valid, dec_out_corrected, 2'b0, dec_out_data}, 8'h89);
      @(negedge clk);
    end
    dec_out_ready = 1'b1;
    #1;
    chk(dec_in_ready === 1'b1, "R7", {7'd0, dec_in_ready}, 8'd1);
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(dec_out_valid === 1'b1 && dec_out_data === 4'h6 && dec_out_corrected === 1'b1,
        "R7", {dec_out_valid, dec_out_corrected, 2'b0, dec_out_data}, 8'hC6);
    @(negedge clk);
    chk(dec_out_valid === 1'b0, "R9", {7'd0, dec_out_valid}, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule